// File: doc/BRIEF.md
# Up/Down Reload-Capture Timer

A 16-bit timer/counter paired with a 16-bit reload/capture register. It advances either on an internal machine-cycle strobe, which is the fast clock divided by `TICK_DIV`, or on falling edges of an external count pin. One trigger pin does a different job in each function. In plain auto-reload it forces a reload. In capture it latches the live count. In up/down auto-reload it picks the counting direction. In baud-clock generation it raises an extra interrupt. The block provides an overflow flag, an external-trigger flag, a combined interrupt request and a one-cycle overflow pulse that a serial transmitter can use as its bit clock.

Software reaches six byte-wide registers through a synchronous port. A write takes effect at the clock edge where `wr_en` is high. Read data is registered: `rdata` shows the register selected by `addr` one clock after `addr` is presented. Register map: 0 control, 1 mode, 2 reload low byte, 3 reload high byte, 4 count low byte, 5 count high byte. Control bits: 0 run, 1 count source (1 = external pin), 2 capture select, 3 trigger enable, 4 transmit-baud select, 5 receive-baud select, 6 external flag, 7 overflow flag. Mode bit 0 is the direction enable. The other mode bits read as 0.

The machine-cycle and baud dividers are held at zero while run is clear, so the first strobe arrives `TICK_DIV` (or `BAUD_DIV`) clocks after run is set. Both pins pass through a two-stage synchronizer. They are then sampled once per machine cycle. A falling edge is a sample of 1 followed by a sample of 0, and it takes effect in the cycle that takes the 0 sample. When software and hardware update the same register in the same cycle, the software write wins.

Top module: `updn_timer`

## Requirements
- R1: With run (control bit 0) clear, the count never changes except by a software write, whatever the pins do.
- R2: With count source 0, the count rises by one every `TICK_DIV` clocks after run is set. With count source 1, it rises by one per falling edge of `cnt_pin` whose high and low levels each last at least one machine cycle, and internal strobes are not counted.
- R3: In auto-reload with direction enable 0, stepping from FFFFH loads the reload value, sets the overflow flag (bit 7) and gives one single-cycle `ovf_pulse`.
- R4: In auto-reload with direction enable 0, a trigger falling edge loads the reload value and sets the external flag (bit 6) only if trigger enable (bit 3) is 1. With trigger enable 0, the edge has no effect.
- R5: With direction enable 1, a high trigger level counts up and a low level counts down. Counting down from a count equal to the reload value loads FFFFH and sets the overflow flag.
- R6: With direction enable 1, the external flag toggles on every overflow and underflow, and it does not raise `irq` in this mode.
- R7: With capture select 1 and trigger enable 1, a trigger falling edge copies the count from before that step into the reload register and sets the external flag. In capture select the count only rises, and it wraps from FFFFH to 0000H with the overflow flag set and the reload register unchanged.
- R8: When either baud select bit is 1, the timer steps every `BAUD_DIV` clocks. It reloads on overflow and pulses `ovf_pulse`, but it never sets the overflow flag. With trigger enable, a trigger falling edge sets the external flag without a reload.
- R9: After reset every register reads 00H, and `irq` and `ovf_pulse` are 0. `irq` is the overflow flag OR the external flag, except in up/down mode, where only the overflow flag counts.
- R10: Written values read back on the next read. Mode bits other than bit 0 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, the oscillator rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register select |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| cnt_pin | input | 1 | External count input |
| trig_pin | input | 1 | Reload/capture/direction trigger input |
| irq | output | 1 | Interrupt request |
| ovf_pulse | output | 1 | One-cycle pulse on each overflow or underflow |

## Verification
The run length is swept in machine-cycle counts, which separates correct strobe spacing from off-by-one prescaling. The external pin is pulsed a varying number of times, which separates edge counting from level counting and from counting internal strobes. The baud function is swept over reload values one to five steps below the top, and the bench derives the final count and the number of overflow pulses from the step count modulo the period. This exposes a wrong reload point or a flag that should stay suppressed. Trigger edges are placed at a known machine cycle, so reload, capture and direction behaviour can each be checked against an exact count.

// File: rtl/updn_timer_pkg.sv
package updn_timer_pkg;

    localparam int unsigned CNT_W  = 16;
    localparam int unsigned BYTE_W = 8;

    // register addresses
    localparam logic [2:0] ADR_CTRL = 3'd0;
    localparam logic [2:0] ADR_MODE = 3'd1;
    localparam logic [2:0] ADR_RLO  = 3'd2;
    localparam logic [2:0] ADR_RHI  = 3'd3;
    localparam logic [2:0] ADR_CLO  = 3'd4;
    localparam logic [2:0] ADR_CHI  = 3'd5;

    // control register, bit 7 down to bit 0
    typedef struct packed {
        logic ovf;      // overflow flag
        logic ext;      // external trigger flag
        logic rx_baud;  // receive baud select
        logic tx_baud;  // transmit baud select
        logic ext_en;   // trigger enable
        logic cap_sel;  // capture select
        logic ext_src;  // count external pin edges
        logic run;      // run
    } ctrl_t;

    typedef enum logic [1:0] {
        F_RELOAD  = 2'd0,
        F_UPDOWN  = 2'd1,
        F_CAPTURE = 2'd2,
        F_BAUD    = 2'd3
    } func_e;

    typedef struct packed {
        ctrl_t              ctrl;
        logic               dir_en;
        logic [CNT_W-1:0]   cnt;
        logic [CNT_W-1:0]   rld;
        logic [BYTE_W-1:0]  rdata;
        logic               pulse;
    } state_t;

endpackage

// File: rtl/updn_timer_sync.sv
module updn_timer_sync #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    logic [N-1:0] st1_q, st2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st1_q <= '0;
            st2_q <= '0;
        end else begin
            st1_q <= din;
            st2_q <= st1_q;
        end
    end

    assign dout = st2_q;
endmodule

// File: rtl/updn_timer_strobe.sv
module updn_timer_strobe #(
    parameter int unsigned DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] c_q, c_d;

    always_comb begin
        c_d = c_q;
        if (!en)
            c_d = '0;
        else if (c_q == LAST)
            c_d = '0;
        else
            c_d = c_q + 1'b1;
    end

    assign tick = en && (c_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end
endmodule

// File: rtl/updn_timer_edge.sv
module updn_timer_edge #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sample,
    input  logic [N-1:0] din,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev_q, prev_d;

    for (genvar i = 0; i < N; i++) begin : g_pin
        assign fall[i]   = sample & prev_q[i] & ~din[i];
        assign prev_d[i] = sample ? din[i] : prev_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/updn_timer.sv
module updn_timer
    import updn_timer_pkg::*;
#(
    parameter int unsigned TICK_DIV = 12,
    parameter int unsigned BAUD_DIV = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  addr,
    input  logic        wr_en,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    input  logic        cnt_pin,
    input  logic        trig_pin,
    output logic        irq,
    output logic        ovf_pulse
);
    localparam int unsigned PIN_N    = 2;
    localparam int unsigned PIN_CNT  = 0;
    localparam int unsigned PIN_TRIG = 1;
    localparam logic [CNT_W-1:0] TOP = '1;

    state_t s_q, s_d;

    logic [PIN_N-1:0] pins_raw, pins_sync, pins_fall;
    logic             mc_tick, baud_tick;

    // named views used by the logic and by the bound checker
    logic             run_w, baud_w, step, trig_hit, dir_up;
    logic             ovf_flag_w, ext_flag_w;
    logic [CNT_W-1:0] cnt_w, rld_w;
    func_e            func;

    assign pins_raw = {trig_pin, cnt_pin};

    updn_timer_sync #(.N(PIN_N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pins_raw),
        .dout  (pins_sync)
    );

    updn_timer_strobe #(.DIV(TICK_DIV)) u_mc_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (s_q.ctrl.run),
        .tick  (mc_tick)
    );

    updn_timer_strobe #(.DIV(BAUD_DIV)) u_baud_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (s_q.ctrl.run),
        .tick  (baud_tick)
    );

    updn_timer_edge #(.N(PIN_N)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sample (mc_tick),
        .din    (pins_sync),
        .fall   (pins_fall)
    );

    assign run_w      = s_q.ctrl.run;
    assign baud_w     = s_q.ctrl.tx_baud | s_q.ctrl.rx_baud;
    assign ovf_flag_w = s_q.ctrl.ovf;
    assign ext_flag_w = s_q.ctrl.ext;
    assign cnt_w      = s_q.cnt;
    assign rld_w      = s_q.rld;
    assign dir_up     = pins_sync[PIN_TRIG];
    assign trig_hit   = pins_fall[PIN_TRIG] & s_q.ctrl.ext_en;

    always_comb begin
        if (baud_w)
            func = F_BAUD;
        else if (s_q.ctrl.cap_sel)
            func = F_CAPTURE;
        else if (s_q.dir_en)
            func = F_UPDOWN;
        else
            func = F_RELOAD;
    end

    always_comb begin
        if (!s_q.ctrl.run)
            step = 1'b0;
        else if (s_q.ctrl.ext_src)
            step = pins_fall[PIN_CNT];
        else if (baud_w)
            step = baud_tick;
        else
            step = mc_tick;
    end

    // next-state logic
    always_comb begin
        s_d       = s_q;
        s_d.pulse = 1'b0;

        unique case (func)
            F_RELOAD: begin
                if (trig_hit) begin
                    s_d.cnt      = s_q.rld;
                    s_d.ctrl.ext = 1'b1;
                end else if (step) begin
                    if (s_q.cnt == TOP) begin
                        s_d.cnt      = s_q.rld;
                        s_d.ctrl.ovf = 1'b1;
                        s_d.pulse    = 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
            end
            F_UPDOWN: begin
                if (step) begin
                    if (dir_up) begin
                        if (s_q.cnt == TOP) begin
                            s_d.cnt      = s_q.rld;
                            s_d.ctrl.ovf = 1'b1;
                            s_d.ctrl.ext = ~s_q.ctrl.ext;
                            s_d.pulse    = 1'b1;
                        end else begin
                            s_d.cnt = s_q.cnt + 1'b1;
                        end
                    end else begin
                        if (s_q.cnt == s_q.rld) begin
                            s_d.cnt      = TOP;
                            s_d.ctrl.ovf = 1'b1;
                            s_d.ctrl.ext = ~s_q.ctrl.ext;
                            s_d.pulse    = 1'b1;
                        end else begin
                            s_d.cnt = s_q.cnt - 1'b1;
                        end
                    end
                end
            end
            F_CAPTURE: begin
                if (step) begin
                    if (s_q.cnt == TOP) begin
                        s_d.cnt      = '0;
                        s_d.ctrl.ovf = 1'b1;
                        s_d.pulse    = 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                if (trig_hit) begin
                    s_d.rld      = s_q.cnt;
                    s_d.ctrl.ext = 1'b1;
                end
            end
            F_BAUD: begin
                if (step) begin
                    if (s_q.cnt == TOP) begin
                        s_d.cnt   = s_q.rld;
                        s_d.pulse = 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                if (trig_hit)
                    s_d.ctrl.ext = 1'b1;
            end
            default: ;
        endcase

        // software write overrides hardware in the same cycle
        if (wr_en) begin
            unique case (addr)
                ADR_CTRL: s_d.ctrl              = ctrl_t'(wdata);
                ADR_MODE: s_d.dir_en            = wdata[0];
                ADR_RLO:  s_d.rld[BYTE_W-1:0]   = wdata;
                ADR_RHI:  s_d.rld[CNT_W-1:BYTE_W] = wdata;
                ADR_CLO:  s_d.cnt[BYTE_W-1:0]   = wdata;
                ADR_CHI:  s_d.cnt[CNT_W-1:BYTE_W] = wdata;
                default: ;
            endcase
        end

        // registered read path
        unique case (addr)
            ADR_CTRL: s_d.rdata = s_q.ctrl;
            ADR_MODE: s_d.rdata = {{(BYTE_W-1){1'b0}}, s_q.dir_en};
            ADR_RLO:  s_d.rdata = s_q.rld[BYTE_W-1:0];
            ADR_RHI:  s_d.rdata = s_q.rld[CNT_W-1:BYTE_W];
            ADR_CLO:  s_d.rdata = s_q.cnt[BYTE_W-1:0];
            ADR_CHI:  s_d.rdata = s_q.cnt[CNT_W-1:BYTE_W];
            default:  s_d.rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rdata     = s_q.rdata;
    assign ovf_pulse = s_q.pulse;
    assign irq       = s_q.ctrl.ovf | (s_q.ctrl.ext & (func != F_UPDOWN));

endmodule

// File: rtl/updn_timer_check.sv
module updn_timer_check
    import updn_timer_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             run_w,
    input logic             baud_w,
    input logic             step,
    input logic             trig_hit,
    input logic             dir_up,
    input func_e            func,
    input logic [CNT_W-1:0] cnt_w,
    input logic [CNT_W-1:0] rld_w,
    input logic             ovf_flag_w,
    input logic             ext_flag_w,
    input logic             ovf_pulse
);
    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_w && !wr_en) |=> $stable(cnt_w));

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |=> !ovf_pulse);

    assert_trig_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (func == F_RELOAD && trig_hit && !wr_en) |=> (cnt_w == $past(rld_w) && ext_flag_w));

    assert_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (func == F_UPDOWN && step && !dir_up && cnt_w == rld_w && !wr_en)
        |=> (cnt_w == '1 && ovf_flag_w));

    assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (func == F_CAPTURE && trig_hit && !wr_en) |=> (rld_w == $past(cnt_w)));

    assert_no_ovf_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (baud_w && !wr_en) |=> !$rose(ovf_flag_w));
endmodule

bind updn_timer updn_timer_check u_check (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .run_w      (run_w),
    .baud_w     (baud_w),
    .step       (step),
    .trig_hit   (trig_hit),
    .dir_up     (dir_up),
    .func       (func),
    .cnt_w      (cnt_w),
    .rld_w      (rld_w),
    .ovf_flag_w (ovf_flag_w),
    .ext_flag_w (ext_flag_w),
    .ovf_pulse  (ovf_pulse)
);

// File: tb/updn_timer_bench.sv
module updn_timer_bench;
    localparam int TDIV = 4;
    localparam int BDIV = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       cnt_pin = 1'b1;
    logic       trig_pin = 1'b1;
    logic       irq, ovf_pulse;

    int total = 0;
    int bad = 0;
    int pulses = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    updn_timer #(.TICK_DIV(TDIV), .BAUD_DIV(BDIV)) u_updn_timer (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .cnt_pin(cnt_pin), .trig_pin(trig_pin),
        .irq(irq), .ovf_pulse(ovf_pulse)
    );

    always @(negedge clk) if (rst_n && ovf_pulse) pulses++;

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a;
        @(negedge clk);
        v = rdata;
    endtask

    task automatic set_cnt(input logic [15:0] v);
        wr(3'd4, v[7:0]); wr(3'd5, v[15:8]);
    endtask

    task automatic set_rld(input logic [15:0] v);
        wr(3'd2, v[7:0]); wr(3'd3, v[15:8]);
    endtask

    task automatic get16(input logic [2:0] lo, output logic [15:0] v);
        logic [7:0] l, h;
        rd(lo, l); rd(lo + 3'd1, h);
        v = {h, l};
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] w;
        int p0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), b);
            chk("R9 reset reg", b, 0);
        end
        chk("R9 reset irq", irq, 0);
        chk("R9 reset pulse", ovf_pulse, 0);

        // R10: register access
        set_rld(16'h1234);
        get16(3'd2, w);
        chk("R10 reload readback", w, 16'h1234);
        wr(3'd1, 8'hFE); rd(3'd1, b);
        chk("R10 mode unused bits", b, 0);
        wr(3'd1, 8'h01); rd(3'd1, b);
        chk("R10 mode bit0", b, 1);
        wr(3'd1, 8'h00);

        // R1: stopped timer holds, pins toggling, external source selected
        set_cnt(16'h0100);
        wr(3'd0, 8'h02);
        for (int i = 0; i < 4; i++) begin
            cnt_pin = 1'b0; trig_pin = 1'b0; repeat (10) @(negedge clk);
            cnt_pin = 1'b1; trig_pin = 1'b1; repeat (10) @(negedge clk);
        end
        get16(3'd4, w);
        chk("R1 hold while stopped", w, 16'h0100);

        // R2: internal timing sweep, k machine cycles
        for (int k = 1; k <= 6; k++) begin
            set_cnt(16'h00F0);
            wr(3'd0, 8'h01);
            repeat (TDIV * k) @(negedge clk);
            wr(3'd0, 8'h00);
            get16(3'd4, w);
            chk("R2 timer steps", w, 16'h00F0 + k);
        end

        // R2: external edge counting, n pulses
        for (int n = 1; n <= 4; n++) begin
            set_cnt(16'h0000);
            wr(3'd0, 8'h03);
            for (int i = 0; i < n; i++) begin
                cnt_pin = 1'b0; repeat (3 * TDIV) @(negedge clk);
                cnt_pin = 1'b1; repeat (3 * TDIV) @(negedge clk);
            end
            repeat (3 * TDIV) @(negedge clk);
            wr(3'd0, 8'h00);
            get16(3'd4, w);
            chk("R2 edge count", w, n);
        end

        // R3: overflow reload FFFE -> FFFF -> 1234 -> 1235
        set_rld(16'h1234); set_cnt(16'hFFFE);
        p0 = pulses;
        wr(3'd0, 8'h01);
        repeat (10) @(negedge clk);
        rd(3'd0, b);
        chk("R3 overflow flag", b, 8'h81);
        chk("R3 irq", irq, 1);
        wr(3'd0, 8'h00);
        get16(3'd4, w);
        chk("R3 reload count", w, 16'h1235);
        chk("R3 one pulse", pulses - p0, 1);

        // R4: trigger edge with enable clear has no effect
        set_rld(16'h0500); set_cnt(16'h0010);
        wr(3'd0, 8'h01);
        trig_pin = 1'b0; repeat (6) @(negedge clk);
        trig_pin = 1'b1; repeat (6) @(negedge clk);
        chk("R4 no ext irq", irq, 0);
        wr(3'd0, 8'h00);
        get16(3'd4, w);
        chk("R4 edge ignored", w, 16'h0013);

        // R4: trigger edge with enable reloads at first machine cycle
        set_cnt(16'h0010);
        p0 = pulses;
        wr(3'd0, 8'h09);
        trig_pin = 1'b0; repeat (6) @(negedge clk);
        trig_pin = 1'b1; repeat (4) @(negedge clk);
        rd(3'd0, b);
        chk("R4 ext flag", b, 8'h49);
        chk("R4 irq", irq, 1);
        wr(3'd0, 8'h00);
        get16(3'd4, w);
        chk("R4 edge reload", w, 16'h0502);
        chk("R4 no pulse", pulses - p0, 0);

        // R5: down count through reload value
        wr(3'd1, 8'h01);
        trig_pin = 1'b0;
        set_rld(16'h0100); set_cnt(16'h0102);
        wr(3'd0, 8'h01);
        repeat (12) @(negedge clk);
        rd(3'd0, b);
        chk("R5 underflow flags", b, 8'hC1);
        wr(3'd0, 8'h00);
        get16(3'd4, w);
        chk("R5 down count", w, 16'hFFFE);

        // R5: up count when trigger high
        trig_pin = 1'b1;
        set_cnt(16'h0200);
        wr(3'd0, 8'h01);
        repeat (8) @(negedge clk);
        wr(3'd0, 8'h00);
        get16(3'd4, w);
        chk("R5 up count", w, 16'h0202);

        // R6: ext flag toggles per overflow
        set_rld(16'hFFFE); set_cnt(16'hFFFF);
        p0 = pulses;
        wr(3'd0, 8'h01);
        repeat (4) @(negedge clk);
        rd(3'd0, b);
        chk("R6 first toggle", b, 8'hC1);
        repeat (6) @(negedge clk);
        rd(3'd0, b);
        chk("R6 second toggle", b, 8'h81);
        wr(3'd0, 8'h00);
        chk("R6 two pulses", pulses - p0, 2);

        // R6 / R9: ext flag masked from irq only in up/down mode
        set_rld(16'h0000); set_cnt(16'h0000);
        wr(3'd0, 8'h41);
        repeat (3) @(negedge clk);
        chk("R6 irq masked", irq, 0);
        wr(3'd1, 8'h00);
        @(negedge clk);
        chk("R9 irq from ext flag", irq, 1);
        wr(3'd0, 8'h00);

        // R7: capture of pre-step count
        set_rld(16'h0000); set_cnt(16'h0300);
        wr(3'd0, 8'h0D);
        trig_pin = 1'b0; repeat (6) @(negedge clk);
        trig_pin = 1'b1; repeat (4) @(negedge clk);
        rd(3'd0, b);
        chk("R7 capture flag", b, 8'h4D);
        wr(3'd0, 8'h00);
        get16(3'd2, w);
        chk("R7 captured value", w, 16'h0300);
        get16(3'd4, w);
        chk("R7 count continues", w, 16'h0303);

        // R7: capture select wraps to zero, reload untouched
        set_rld(16'h5555); set_cnt(16'hFFFF);
        wr(3'd0, 8'h05);
        repeat (4) @(negedge clk);
        rd(3'd0, b);
        chk("R7 wrap flag", b, 8'h85);
        wr(3'd0, 8'h00);
        get16(3'd4, w);
        chk("R7 wrap count", w, 16'h0001);
        get16(3'd2, w);
        chk("R7 reload kept", w, 16'h5555);

        // R8: baud sweep over periods 1..5
        for (int p = 1; p <= 5; p++) begin
            logic [15:0] r;
            r = 16'(65536 - p);
            set_rld(r); set_cnt(r);
            p0 = pulses;
            wr(3'd0, (p % 2 == 1) ? 8'h11 : 8'h21);
            repeat (18) @(negedge clk);
            rd(3'd0, b);
            chk("R8 no ovf flag", b, (p % 2 == 1) ? 8'h11 : 8'h21);
            chk("R8 irq quiet", irq, 0);
            wr(3'd0, 8'h00);
            get16(3'd4, w);
            chk("R8 baud count", w, 16'(r + (11 % p)));
            chk("R8 baud pulses", pulses - p0, 11 / p);
        end

        // R8: trigger edge sets ext flag without reload
        set_rld(16'hF000); set_cnt(16'hF000);
        wr(3'd0, 8'h29);
        trig_pin = 1'b0; repeat (6) @(negedge clk);
        trig_pin = 1'b1; repeat (4) @(negedge clk);
        rd(3'd0, b);
        chk("R8 extra interrupt flag", b, 8'h69);
        chk("R8 irq", irq, 1);
        wr(3'd0, 8'h00);
        get16(3'd4, w);
        chk("R8 no reload on edge", w, 16'hF007);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule